// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out word buffer with a strobe handshake on each side. By default it holds 64 words of 4 bits. A producer raises a write strobe to hand over the word on the data inputs. A consumer lowers a read strobe to take away the word shown at the output. Between these two points, words move toward the output without any read request. The oldest released word is always present at `q`. Two flags tell each side whether it may strobe: `in_ready` for the producer and `out_ready` for the consumer.

Everything runs on one system clock. Both strobes are sampled on every rising clock edge, and the block acts on the changes between successive samples. Each transfer takes one clock, so the short flag pulses of the two automatic-transfer cases each last exactly one clock cycle.

Top module: `ftf_fifo`

## Requirements
- R1: Words leave in the order they were written. Up to DEPTH (default 64) words can be held at once.
- R2: A word on `din` is taken in at the clock edge where `shift_in` is first sampled high after being low. It becomes visible at `q`, with `out_ready` high, in the cycle after the first edge at which `shift_in` is sampled low again. No read action is needed for this.
- R3: The word at `q` is removed at the first edge where `shift_out` is sampled low after being high. The next stored word appears at `q` in the following cycle.
- R4: A rising `shift_in` while DEPTH words are held is ignored. The held contents and their order stay unchanged, and `in_ready` stays low.
- R5: A falling `shift_out` with no visible word is ignored. `q` keeps the last removed word until a new word becomes visible or reset is applied.
- R6: `out_ready` is high only while a visible word is at `q`. Outside the automatic case of R8, it is low while `shift_out` is high.
- R7: `in_ready` is low while DEPTH words are held. Outside the automatic case of R9, it is low while `shift_in` is high and high otherwise.
- R8: Suppose `shift_out` goes high while no word is visible and stays high. When a word then becomes visible, `out_ready` is high for exactly one cycle and the word is removed at that edge. The later fall of the same strobe removes nothing more.
- R9: Suppose a rising `shift_in` is refused because the buffer is full, and `shift_in` stays high. When a word is later removed, `in_ready` is high for exactly one cycle, and the word on `din` is taken in at that edge.
- R10: While `rst_n` is low, the buffer is emptied, `q` reads 0, `out_ready` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_in | input | 1 | Write strobe; its rising edge takes in `din` |
| shift_out | input | 1 | Read strobe; its falling edge removes the word at `q` |
| din | input | WIDTH | Word to be written |
| q | output | WIDTH | Oldest visible word, or the last removed word when none is visible |
| in_ready | output | 1 | Buffer can take a word |
| out_ready | output | 1 | A valid word is present at `q` |

## Verification
The flags and `q` are combinational functions of the registered state and the present strobe levels. A strobe change therefore shows on the flags within the same cycle. A strobe edge that moves a word shows on `q` and the flags in the cycle after the edge at which it is sampled. A newly written word shows one cycle after the first edge that sees `shift_in` low. The reference model in the bench advances at each rising edge from the same sampled inputs, and the outputs are compared a quarter period after the falling edge, once the new input levels have settled. The directed checks wait a fixed number of cycles after each strobe task so that they always look at a settled state. Two counters, one per flag, count the cycles in which a flag is high while its own strobe is high, and these counts confirm that each automatic pulse lasts exactly one cycle.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
   // sampled strobe: present level and the edges found against the previous sample
   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } strobe_t;

   localparam int unsigned NUM_STROBES = 2;
   localparam int unsigned STB_WR      = 0;
   localparam int unsigned STB_RD      = 1;
endpackage

// File: rtl/ftf_strobe.sv
module ftf_strobe
   import ftf_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    lvl,
   output strobe_t stb
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      stb.lvl  = lvl;
      stb.rise = lvl & ~prev_q;
      stb.fall = ~lvl & prev_q;
   end
endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl
   import ftf_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t wr,
   input  strobe_t rd,
   output logic    push,
   output logic    pop,
   output logic    full,
   output logic    vis_nz,
   output logic    in_ready,
   output logic    out_ready
);
   logic [CW-1:0] cnt_q;
   logic          held_q;   // newest word still waiting for the write strobe to drop
   logic          warm_q;   // refused write strobe still high
   logic          rarm_q;   // read strobe raised on an empty output
   logic          spent_q;  // read strobe already used by an automatic removal
   logic          auto_rd;

   always_comb begin
      full      = (cnt_q == CW'(DEPTH));
      vis_nz    = (cnt_q > CW'(held_q));
      auto_rd   = vis_nz & rd.lvl & rarm_q;
      pop       = vis_nz & ((rd.fall & ~spent_q) | auto_rd);
      push      = wr.lvl & (wr.rise | warm_q) & ~full;
      in_ready  = ~full & (~wr.lvl | warm_q);
      out_ready = vis_nz & (~rd.lvl | rarm_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         held_q  <= 1'b0;
         warm_q  <= 1'b0;
         rarm_q  <= 1'b0;
         spent_q <= 1'b0;
      end else begin
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
         held_q  <= push | (held_q & wr.lvl & ~wr.fall);
         warm_q  <= wr.lvl & (wr.rise | warm_q) & ~push;
         rarm_q  <= rd.lvl & (rd.rise | rarm_q) & ~vis_nz;
         spent_q <= rd.lvl & (spent_q | auto_rd);
      end
   end
endmodule

// File: rtl/ftf_store.sv
module ftf_store #(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam bit          PW2  = ((1 << AW) == DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             vis_nz,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] last_q;
   logic [AW-1:0]    wptr_q, rptr_q, wnext, rnext;

   if (PW2) begin : g_wrap_nat
      assign wnext = wptr_q + AW'(1);
      assign rnext = rptr_q + AW'(1);
   end else begin : g_wrap_cmp
      assign wnext = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      assign rnext = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         last_q <= '0;
      end else begin
         if (push) wptr_q <= wnext;
         if (pop) begin
            rptr_q <= rnext;
            last_q <= mem[rptr_q];
         end
      end
   end

   assign q = vis_nz ? mem[rptr_q] : last_q;
endmodule

// File: rtl/ftf_fifo.sv
module ftf_fifo
   import ftf_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_in,
   input  logic             shift_out,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             in_ready,
   output logic             out_ready
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ftf_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ftf_fifo: WIDTH must be at least 1");
   end

   logic [NUM_STROBES-1:0] lvls;
   strobe_t                stbs [NUM_STROBES];
   logic push, pop, full, vis_nz;

   assign lvls[STB_WR] = shift_in;
   assign lvls[STB_RD] = shift_out;

   for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
      ftf_strobe u_stb (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (lvls[g]),
         .stb  (stbs[g])
      );
   end

   ftf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (stbs[STB_WR]),
      .rd       (stbs[STB_RD]),
      .push     (push),
      .pop      (pop),
      .full     (full),
      .vis_nz   (vis_nz),
      .in_ready (in_ready),
      .out_ready(out_ready)
   );

   ftf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .vis_nz(vis_nz),
      .din   (din),
      .q     (q)
   );
endmodule

// File: rtl/ftf_fifo_chk.sv
module ftf_fifo_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_lvl,
   input logic             rd_lvl,
   input logic [WIDTH-1:0] q,
   input logic             in_ready,
   input logic             out_ready,
   input logic             full,
   input logic             vis_nz
);
   // R7: no acceptance signalled while storage is full
   a_r7_ir_low_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !in_ready);

   // R6: output flag only with a visible word
   a_r6_or_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_nz |-> !out_ready);

   // R8: flag high during a held read strobe lasts a single cycle
   a_r8_or_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && rd_lvl) |=> (!out_ready || !rd_lvl));

   // R9: flag high during a held write strobe lasts a single cycle
   a_r9_ir_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && wr_lvl) |=> (!in_ready || !wr_lvl));

   // R5: with nothing visible the output word does not change
   a_r5_q_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vis_nz |=> (vis_nz || $stable(q)));
endmodule

bind ftf_fifo ftf_fifo_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_lvl   (shift_in),
   .rd_lvl   (shift_out),
   .q        (q),
   .in_ready (in_ready),
   .out_ready(out_ready),
   .full     (full),
   .vis_nz   (vis_nz)
);

// File: tb/sim_ftf_fifo.sv
module sim_ftf_fifo;
   localparam int CLK_P = 10;
   localparam int W     = 4;
   localparam int D     = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         si = 1'b0, so = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic         in_ready, out_ready;

   int total = 0, bad = 0;
   bit done = 0, live = 0;
   int ir_pulses = 0, or_pulses = 0;

   ftf_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .shift_in(si), .shift_out(so), .din(din),
      .q(q), .in_ready(in_ready), .out_ready(out_ready)
   );

   always #(CLK_P/2) clk = ~clk;

   // behavioural reference: a queue plus strobe bookkeeping
   logic [W-1:0] mq[$];
   logic [W-1:0] m_last;
   int  m_hold;
   bit  m_sip, m_sop, m_warm, m_rarm, m_spent;

   function automatic int vis();
      return mq.size() - m_hold;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete(); m_last = '0; m_hold = 0;
         m_sip = 0; m_sop = 0; m_warm = 0; m_rarm = 0; m_spent = 0;
      end else begin
         bit sr, sor, sof, take, give, autor;
         int v;
         v     = vis();
         sr    = si && !m_sip;
         sor   = so && !m_sop;
         sof   = !so && m_sop;
         autor = (v > 0) && so && m_rarm;
         take  = (v > 0) && ((sof && !m_spent) || autor);
         give  = si && (sr || m_warm) && (mq.size() < D);
         if (take) m_last = mq.pop_front();
         if (give) mq.push_back(din);
         m_hold  = give ? 1 : ((si && m_hold != 0) ? 1 : 0);
         m_warm  = si && (sr || m_warm) && !give;
         m_rarm  = so && (sor || m_rarm) && (v == 0);
         m_spent = so && (m_spent || autor);
         m_sip = si; m_sop = so;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model, after inputs settle
   always @(negedge clk) begin
      #(CLK_P/4);
      if (rst_n && live) begin
         logic [W-1:0] eq;
         bit eor, eir;
         eq  = (vis() > 0) ? mq[0] : m_last;
         eor = (vis() > 0) && (!so || m_rarm);
         eir = (mq.size() < D) && (!si || m_warm);
         chk(q == eq, "R1 q vs model", q, eq);
         chk(out_ready == eor, "R6 out_ready vs model", out_ready, eor);
         chk(in_ready == eir, "R7 in_ready vs model", in_ready, eir);
         if (in_ready && si) ir_pulses++;
         if (out_ready && so) or_pulses++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic smp();
      @(negedge clk); #(CLK_P/4 + 1);
   endtask
   task automatic push(input logic [W-1:0] w);
      @(negedge clk); din = w; si = 1'b1;
      cyc(2); si = 1'b0;
      cyc(2);
   endtask
   task automatic pop();
      @(negedge clk); so = 1'b1;
      cyc(2); so = 1'b0;
      cyc(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cyc(3);
      smp();
      chk(q == 4'h0, "R10 reset q", q, 0);
      chk(out_ready == 1'b0, "R10 reset out_ready", out_ready, 0);
      chk(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
      @(negedge clk); rst_n = 1'b1; live = 1;
      cyc(2);

      push(4'h5); push(4'h9); push(4'h3);
      smp();
      chk(q == 4'h5, "R2 first word falls through", q, 5);
      chk(out_ready == 1'b1, "R2 out_ready after fall-through", out_ready, 1);
      pop(); smp();
      chk(q == 4'h9, "R3 next word after read", q, 9);
      pop(); pop(); smp();
      chk(q == 4'h3, "R5 last word kept", q, 3);
      chk(out_ready == 1'b0, "R6 empty out_ready", out_ready, 0);
      pop(); smp();
      chk(q == 4'h3, "R5 read on empty ignored", q, 3);

      for (int i = 0; i < D; i++) push(W'(i) ^ 4'hA);
      smp();
      chk(in_ready == 1'b0, "R7 full in_ready", in_ready, 0);
      push(4'hF);
      smp();
      chk(in_ready == 1'b0, "R4 write on full ignored", in_ready, 0);
      for (int i = 0; i < D; i++) begin
         smp();
         chk(q == (W'(i) ^ 4'hA), "R1 order", q, W'(i) ^ 4'hA);
         pop();
      end
      smp();
      chk(q == 4'h5, "R4 extra word absent", q, 5);
      chk(out_ready == 1'b0, "R4 empty after drain", out_ready, 0);

      // automatic read on an empty buffer
      @(negedge clk); so = 1'b1; cyc(2);
      or_pulses = 0;
      push(4'h6); cyc(3);
      chk(or_pulses == 1, "R8 out_ready single pulse", or_pulses, 1);
      push(4'h7); cyc(2);
      @(negedge clk); so = 1'b0; cyc(2);
      smp();
      chk(q == 4'h7, "R8 strobe fall removes nothing more", q, 7);
      chk(out_ready == 1'b1, "R8 word still held", out_ready, 1);
      pop();

      // automatic write on a full buffer
      for (int i = 0; i < D; i++) push(W'(i) ^ 4'h3);
      @(negedge clk); din = 4'hC; si = 1'b1; cyc(2);
      smp();
      chk(in_ready == 1'b0, "R9 refused while full", in_ready, 0);
      ir_pulses = 0;
      pop(); cyc(2);
      chk(ir_pulses == 1, "R9 in_ready single pulse", ir_pulses, 1);
      @(negedge clk); si = 1'b0; cyc(2);
      for (int i = 1; i < D; i++) begin
         smp();
         chk(q == (W'(i) ^ 4'h3), "R1 order after auto write", q, W'(i) ^ 4'h3);
         pop();
      end
      smp();
      chk(q == 4'hC, "R9 auto-written word", q, 4'hC);
      pop(); smp();
      chk(out_ready == 1'b0, "R9 empty at end", out_ready, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule